// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block sits beside a processor core. It collects six interrupt sources and picks one of them each time the core acknowledges. It hands the core the address it must continue from. The sources are an invalid-opcode trap signalled by the core, an active-low non-maskable input and four active-low maskable inputs (INT0 to INT3). The maskable inputs are gated by a per-input enable register and by a global enable flag. The external inputs pass through two-flop synchronizers. The non-maskable input is serviced once per falling edge.

When the core pulses `ack`, the block records the winning source, a 32-bit address and two qualifiers. `vec_fetch` says the address points at a table entry that the core must read to get the handler address. `vec_exec_bus` says the core must execute an instruction placed on the bus. These outputs stay fixed until the core pulses `ack_done`. INT0 supports four modes. INT1 to INT3 use fixed-offset table entries inside a page taken from a base register. Stacking the return address and reading the table entry are left to the core.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset: `ier_q` = 4'b0001, `gie` = 0, `nmi_saved_ie` = 0, `avb_q` = 8'h00, `grant_valid` = 0, `irq_req` = 0.
- R2: Priority from highest to lowest is trap, NMI, INT0, INT1, INT2, INT3. `grant_src` encodes these as 0, 1, 2, 3, 4, 5. `int_n[i]` low requests INTi.
- R3: A trap grant gives `vec_addr` = 32'h0000_0000. An NMI grant gives `vec_addr` = 32'h0000_0066. Both have `vec_fetch` = 0 and `vec_exec_bus` = 0.
- R4: An NMI grant copies `gie` into `nmi_saved_ie` and clears `gie`. A trap grant leaves `gie` unchanged.
- R5: A grant to INT1, INT2 or INT3 gives `vec_addr` = {`ireg[23:8]`, `avb_q[7:1]`, 1'b0, low byte}. The low byte is 8'h00 for INT1, 8'h04 for INT2 and 8'h08 for INT3. `vec_fetch` = 1.
- R6: A write to the base register keeps bits 7..1 of `avb_wdata`. `avb_q[0]` always reads 0.
- R7: An INT0 grant depends on `im_mode`, sampled in the `ack` cycle together with `ack_vec`:
  - Mode 0: `vec_addr` = 0, `vec_fetch` = 0, `vec_exec_bus` = 1.
  - Mode 1: `vec_addr` = 32'h38, `vec_fetch` = 0.
  - Mode 2: `vec_addr` = {`ireg`, `ack_vec[7:0]`}, `vec_fetch` = 1.
  - Mode 3: `vec_addr` = {`ireg[23:8]`, `ack_vec`}, `vec_fetch` = 1.
- R8: INTi is serviced only when `ier_q[i]` = 1 and `gie` = 1. `gie_clr` clears only `gie` and leaves `ier_q` unchanged. `irq_req` is high exactly when some source is serviceable.
- R9: `ack` while `grant_valid` = 0 and `irq_req` = 1 raises `grant_valid` on the next cycle. While `grant_valid` = 1, `ack` is ignored and all grant outputs hold. `ack_done` clears `grant_valid` on the next cycle.
- R10: One falling edge on `nmi_n` produces exactly one NMI service. Holding `nmi_n` low afterwards produces no further NMI service.
- R11: Any maskable grant clears `gie`. This takes precedence over a `gie_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Invalid-opcode trap pulse from the core |
| nmi_n | input | 1 | Non-maskable request, active low, asynchronous |
| int_n | input | 4 | Maskable requests INT3..INT0, active low, asynchronous |
| im_mode | input | 2 | INT0 mode 0..3 |
| ireg | input | 24 | Extended I register; bits 23..8 form address bits 31..16 |
| ack_vec | input | 16 | Vector read from the bus in the acknowledge cycle |
| ier_we | input | 1 | Write strobe for the per-input enables |
| ier_wdata | input | 4 | Per-input enable write data |
| avb_we | input | 1 | Write strobe for the vector page base |
| avb_wdata | input | 8 | Vector page base write data |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| ack | input | 1 | Acknowledge pulse from the core |
| ack_done | input | 1 | Core has consumed the grant |
| irq_req | output | 1 | A source is serviceable |
| grant_valid | output | 1 | Grant outputs are valid |
| grant_src | output | 3 | Granted source code |
| vec_addr | output | 32 | Target or table address |
| vec_fetch | output | 1 | Core must read the handler address at `vec_addr` |
| vec_exec_bus | output | 1 | Core must execute an instruction from the bus |
| gie | output | 1 | Global maskable enable |
| nmi_saved_ie | output | 1 | Copy of `gie` taken at the last NMI grant |
| ier_q | output | 4 | Per-input enables INT3..INT0 |
| avb_q | output | 8 | Vector page base, bit 0 reads 0 |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a pending trap and a pending NMI meeting one acknowledge. The bench raises `trap_req` in the same cycle `nmi_n` falls. It then expects the trap on the first acknowledge, with `gie` untouched, and the NMI on the second, with `gie` saved and cleared. The second pair is a maskable grant and a `gie_set` in the same cycle. The bench drives `ack` and `gie_set` together with INT0 pending. It expects the grant to be taken and `gie` to end up low.

// File: rtl/irq_vec_pkg.sv
// Package: shared source codes, mode codes and fixed addresses for the
// interrupt vector unit. Assumes a 32-bit target address space.
package irq_vec_pkg;

    localparam int NUM_MASK  = 4;
    localparam int ADDR_W    = 32;
    localparam int SRC_W     = 3;

    // Source codes; the numeric order is the priority order (0 highest).
    typedef enum logic [SRC_W-1:0] {
        SRC_TRAP = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_INT0 = 3'd2,
        SRC_INT1 = 3'd3,
        SRC_INT2 = 3'd4,
        SRC_INT3 = 3'd5
    } irq_src_e;

    // Modes of the first maskable input.
    typedef enum logic [1:0] {
        IM_BUS_INSTR = 2'd0,
        IM_FIXED     = 2'd1,
        IM_BYTE_VEC  = 2'd2,
        IM_WORD_VEC  = 2'd3
    } int0_mode_e;

    localparam logic [ADDR_W-1:0] TRAP_TARGET = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] NMI_TARGET  = 32'h0000_0066;
    localparam logic [ADDR_W-1:0] IM1_TARGET  = 32'h0000_0038;

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-stage synchronizer for a bundle of asynchronous request lines.
// Assumes each bit is independent; RST_VAL is the idle level of the lines.
module irq_sync #(
    parameter int           WIDTH   = 1,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            // Later stages shift the sampled level on.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Fixed-priority selection among trap, NMI and the enabled maskable inputs.
// Assumes all inputs are already synchronous and active high.
module irq_arbiter
    import irq_vec_pkg::*;
#(
    parameter int N_MASK = NUM_MASK
) (
    input  logic              trap_pend,
    input  logic              nmi_pend,
    input  logic [N_MASK-1:0] int_act,
    input  logic [N_MASK-1:0] int_en,
    input  logic              glob_en,
    output logic              any_req,
    output irq_src_e          winner
);
    logic [N_MASK-1:0] int_ok;

    // Maskable request survives only with its own enable and the global one.
    always_comb int_ok = int_act & int_en & {N_MASK{glob_en}};

    // Pick the highest-priority request; lower maskable index wins.
    always_comb begin
        winner  = SRC_TRAP;
        any_req = 1'b1;
        if (trap_pend) begin
            winner = SRC_TRAP;
        end else if (nmi_pend) begin
            winner = SRC_NMI;
        end else begin
            any_req = 1'b0;
            for (int i = N_MASK - 1; i >= 0; i--) begin
                if (int_ok[i]) begin
                    winner  = irq_src_e'(SRC_W'(int'(SRC_INT0) + i));
                    any_req = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_vecgen.sv
// Module: irq_vecgen
// Computes the target/table address and its qualifiers for a chosen source.
// Assumes the page base arrives as its seven significant bits.
module irq_vecgen
    import irq_vec_pkg::*;
#(
    parameter int ASSOC_STEP = 4,
    parameter int N_ASSOC    = 3
) (
    input  irq_src_e      src,
    input  logic [1:0]    mode,
    input  logic [23:0]   ireg,
    input  logic [6:0]    page_hi,
    input  logic [15:0]   ack_vec,
    output logic [ADDR_W-1:0] addr,
    output logic          fetch,
    output logic          exec_bus
);
    logic [ADDR_W-1:0] assoc_addr [N_ASSOC];

    for (genvar g = 0; g < N_ASSOC; g++) begin : g_assoc
        // Fixed-offset table entry inside the selected page.
        assign assoc_addr[g] = {ireg[23:8], page_hi, 1'b0, 8'(g * ASSOC_STEP)};
    end

    // Select the address form for the source and, for INT0, its mode.
    always_comb begin
        addr     = '0;
        fetch    = 1'b0;
        exec_bus = 1'b0;
        unique case (src)
            SRC_TRAP: addr = TRAP_TARGET;
            SRC_NMI:  addr = NMI_TARGET;
            SRC_INT0: begin
                unique case (int0_mode_e'(mode))
                    IM_BUS_INSTR: exec_bus = 1'b1;
                    IM_FIXED:     addr = IM1_TARGET;
                    IM_BYTE_VEC: begin
                        addr  = {ireg, ack_vec[7:0]};
                        fetch = 1'b1;
                    end
                    IM_WORD_VEC: begin
                        addr  = {ireg[23:8], ack_vec};
                        fetch = 1'b1;
                    end
                    default: addr = '0;
                endcase
            end
            SRC_INT1: begin addr = assoc_addr[0]; fetch = 1'b1; end
            SRC_INT2: begin addr = assoc_addr[1]; fetch = 1'b1; end
            SRC_INT3: begin addr = assoc_addr[2]; fetch = 1'b1; end
            default:  addr = '0;
        endcase
    end
endmodule

// File: rtl/irq_vector_unit.sv
// Module: irq_vector_unit (top)
// Collects trap, NMI and four maskable requests and holds the enables.
// On each acknowledge it latches one grant with its target address until
// the core signals done. Assumes trap_req is synchronous to clk and the
// pins nmi_n/int_n are asynchronous.
module irq_vector_unit
    import irq_vec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_MASK-1:0] IER_RESET = 4'b0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trap_req,
    input  logic        nmi_n,
    input  logic [3:0]  int_n,
    input  logic [1:0]  im_mode,
    input  logic [23:0] ireg,
    input  logic [15:0] ack_vec,
    input  logic        ier_we,
    input  logic [3:0]  ier_wdata,
    input  logic        avb_we,
    input  logic [7:0]  avb_wdata,
    input  logic        gie_set,
    input  logic        gie_clr,
    input  logic        ack,
    input  logic        ack_done,
    output logic        irq_req,
    output logic        grant_valid,
    output logic [2:0]  grant_src,
    output logic [31:0] vec_addr,
    output logic        vec_fetch,
    output logic        vec_exec_bus,
    output logic        gie,
    output logic        nmi_saved_ie,
    output logic [3:0]  ier_q,
    output logic [7:0]  avb_q
);
    localparam int PIN_W = NUM_MASK + 1;

    logic [PIN_W-1:0] pins_s;
    logic             nmi_s, nmi_prev, nmi_fall;
    logic [NUM_MASK-1:0] int_act;
    logic             trap_pend, nmi_pend;
    logic [6:0]       page_hi;
    logic             any_req, take;
    irq_src_e         winner, grant_src_q;
    logic [ADDR_W-1:0] next_addr;
    logic             next_fetch, next_exec;

    irq_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({PIN_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({nmi_n, int_n}),
        .q    (pins_s)
    );

    assign nmi_s    = pins_s[PIN_W-1];
    assign int_act  = ~pins_s[NUM_MASK-1:0];
    assign nmi_fall = nmi_prev & ~nmi_s;

    // Remember the previous synchronized NMI level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev <= 1'b1;
        else        nmi_prev <= nmi_s;
    end

    irq_arbiter #(.N_MASK(NUM_MASK)) u_arb (
        .trap_pend(trap_pend),
        .nmi_pend (nmi_pend),
        .int_act  (int_act),
        .int_en   (ier_q),
        .glob_en  (gie),
        .any_req  (any_req),
        .winner   (winner)
    );

    irq_vecgen #(.ASSOC_STEP(4), .N_ASSOC(3)) u_vec (
        .src     (winner),
        .mode    (im_mode),
        .ireg    (ireg),
        .page_hi (page_hi),
        .ack_vec (ack_vec),
        .addr    (next_addr),
        .fetch   (next_fetch),
        .exec_bus(next_exec)
    );

    assign irq_req = any_req;
    assign take    = ack && !grant_valid && any_req;

    // Trap pending flag: set by the core, cleared when the trap is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_pend <= 1'b0;
        else        trap_pend <= (trap_pend && !(take && winner == SRC_TRAP)) || trap_req;
    end

    // NMI pending flag: set by a falling edge, cleared when the NMI is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend <= 1'b0;
        else        nmi_pend <= (nmi_pend && !(take && winner == SRC_NMI)) || nmi_fall;
    end

    // Per-input enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ier_q <= IER_RESET;
        else if (ier_we) ier_q <= ier_wdata;
    end

    // Vector page base; only the seven upper bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      page_hi <= '0;
        else if (avb_we) page_hi <= avb_wdata[7:1];
    end

    assign avb_q = {page_hi, 1'b0};

    // Global enable and NMI save; acceptance outranks set and clear commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie          <= 1'b0;
            nmi_saved_ie <= 1'b0;
        end else if (take && winner == SRC_NMI) begin
            nmi_saved_ie <= gie;
            gie          <= 1'b0;
        end else if (take && winner != SRC_TRAP) begin
            gie <= 1'b0;
        end else if (gie_clr) begin
            gie <= 1'b0;
        end else if (gie_set) begin
            gie <= 1'b1;
        end
    end

    // Grant register: loaded on an accepted acknowledge, released by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_src_q  <= SRC_TRAP;
            vec_addr     <= '0;
            vec_fetch    <= 1'b0;
            vec_exec_bus <= 1'b0;
        end else if (take) begin
            grant_valid  <= 1'b1;
            grant_src_q  <= winner;
            vec_addr     <= next_addr;
            vec_fetch    <= next_fetch;
            vec_exec_bus <= next_exec;
        end else if (grant_valid && ack_done) begin
            grant_valid <= 1'b0;
        end
    end

    assign grant_src = grant_src_q;
endmodule

// File: rtl/irq_vector_unit_chk.sv
// Module: irq_vector_unit_chk
// Property checker for irq_vector_unit, attached by bind. Observes ports only.
module irq_vector_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic        ack_done,
    input logic        irq_req,
    input logic        grant_valid,
    input logic [2:0]  grant_src,
    input logic [31:0] vec_addr,
    input logic        vec_fetch,
    input logic        gie,
    input logic        nmi_saved_ie,
    input logic [3:0]  ier_q,
    input logic [7:0]  avb_q
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !ack_done |=> grant_valid && $stable(grant_src) && $stable(vec_addr));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && ack_done |=> !grant_valid);

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !grant_valid && irq_req |=> $rose(grant_valid));

    assert_trap_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && grant_src == 3'd0 |-> vec_addr == 32'h0 && !vec_fetch);

    assert_nmi_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && grant_src == 3'd1
        |-> !gie && vec_addr == 32'h66 && nmi_saved_ie == $past(gie));

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && grant_src >= 3'd2
        |-> $past(gie) && ((($past(ier_q) >> (grant_src - 3'd2)) & 4'd1) != 4'd0));

    assert_mask_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && grant_src >= 3'd2 |-> !gie);

    assert_assoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && grant_src >= 3'd3
        |-> vec_fetch && vec_addr[8] == 1'b0
            && vec_addr[15:9] == $past(avb_q[7:1])
            && vec_addr[7:0] == {3'b000, grant_src - 3'd3, 2'b00});
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .ack_done    (ack_done),
    .irq_req     (irq_req),
    .grant_valid (grant_valid),
    .grant_src   (grant_src),
    .vec_addr    (vec_addr),
    .vec_fetch   (vec_fetch),
    .gie         (gie),
    .nmi_saved_ie(nmi_saved_ie),
    .ier_q       (ier_q),
    .avb_q       (avb_q)
);

// File: tb/tb_irq_vector_unit.sv
// Bench for irq_vector_unit: a vector table walked by one loop, then directed
// tests for reset, priority collisions, masking, hold and NMI edge handling.
module tb_irq_vector_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, trap_req, nmi_n, ier_we, avb_we, gie_set, gie_clr, ack, ack_done;
    logic [3:0]  int_n, ier_wdata;
    logic [1:0]  im_mode;
    logic [23:0] ireg;
    logic [15:0] ack_vec;
    logic [7:0]  avb_wdata;
    logic        irq_req, grant_valid, vec_fetch, vec_exec_bus, gie, nmi_saved_ie;
    logic [2:0]  grant_src;
    logic [31:0] vec_addr;
    logic [3:0]  ier_q;
    logic [7:0]  avb_q;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .nmi_n(nmi_n), .int_n(int_n),
        .im_mode(im_mode), .ireg(ireg), .ack_vec(ack_vec), .ier_we(ier_we),
        .ier_wdata(ier_wdata), .avb_we(avb_we), .avb_wdata(avb_wdata),
        .gie_set(gie_set), .gie_clr(gie_clr), .ack(ack), .ack_done(ack_done),
        .irq_req(irq_req), .grant_valid(grant_valid), .grant_src(grant_src),
        .vec_addr(vec_addr), .vec_fetch(vec_fetch), .vec_exec_bus(vec_exec_bus),
        .gie(gie), .nmi_saved_ie(nmi_saved_ie), .ier_q(ier_q), .avb_q(avb_q)
    );

    typedef struct packed {
        logic [3:0]  intn;
        logic        nmi;
        logic [1:0]  im;
        logic [2:0]  src;
        logic [31:0] addr;
        logic        fetch;
        logic        exec;
    } vec_t;

    // ireg = 24'h123456, ack_vec = 16'hBEEF, page base written as 8'hA7.
    localparam vec_t TABLE [10] = '{
        '{4'b1110, 1'b0, 2'd0, 3'd2, 32'h0000_0000, 1'b0, 1'b1},  // R7 mode 0
        '{4'b1110, 1'b0, 2'd1, 3'd2, 32'h0000_0038, 1'b0, 1'b0},  // R7 mode 1
        '{4'b1110, 1'b0, 2'd2, 3'd2, 32'h1234_56EF, 1'b1, 1'b0},  // R7 mode 2
        '{4'b1110, 1'b0, 2'd3, 3'd2, 32'h1234_BEEF, 1'b1, 1'b0},  // R7 mode 3
        '{4'b1101, 1'b0, 2'd1, 3'd3, 32'h1234_A600, 1'b1, 1'b0},  // R5 INT1
        '{4'b1011, 1'b0, 2'd1, 3'd4, 32'h1234_A604, 1'b1, 1'b0},  // R5 INT2
        '{4'b0111, 1'b0, 2'd1, 3'd5, 32'h1234_A608, 1'b1, 1'b0},  // R5 INT3
        '{4'b1111, 1'b1, 2'd1, 3'd1, 32'h0000_0066, 1'b0, 1'b0},  // R3 NMI
        '{4'b0000, 1'b0, 2'd1, 3'd2, 32'h0000_0038, 1'b0, 1'b0},  // R2 all low
        '{4'b1001, 1'b0, 2'd1, 3'd3, 32'h1234_A600, 1'b1, 1'b0}   // R2 INT1 over INT2
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_set();
        gie_set = 1'b1; cyc(1); gie_set = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    task automatic pulse_done();
        ack_done = 1'b1; cyc(1); ack_done = 1'b0;
    endtask

    task automatic nmi_edge();
        nmi_n = 1'b0; cyc(2); nmi_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; nmi_n = 1'b1; int_n = 4'hF; im_mode = 2'd1;
        ireg = 24'h123456; ack_vec = 16'hBEEF; ier_we = 1'b0; ier_wdata = '0;
        avb_we = 1'b0; avb_wdata = '0; gie_set = 1'b0; gie_clr = 1'b0;
        ack = 1'b0; ack_done = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 ier", ier_q, 4'b0001);
        chk("R1 gie", gie, 0);
        chk("R1 saved", nmi_saved_ie, 0);
        chk("R1 avb", avb_q, 0);
        chk("R1 valid", grant_valid, 0);
        chk("R1 req", irq_req, 0);

        // R8 enabled INT0 but global enable off: no request, ack ignored
        int_n = 4'b1110; cyc(4);
        chk("R8 req gated", irq_req, 0);
        pulse_ack();
        chk("R8 no grant", grant_valid, 0);
        int_n = 4'hF; cyc(4);

        // setup and R6 base write
        ier_we = 1'b1; ier_wdata = 4'hF; avb_we = 1'b1; avb_wdata = 8'hA7;
        cyc(1); ier_we = 1'b0; avb_we = 1'b0;
        chk("R6 avb", avb_q, 8'hA6);

        // table walk
        for (int k = 0; k < 10; k++) begin
            pulse_set();
            im_mode = TABLE[k].im;
            int_n   = TABLE[k].intn;
            if (TABLE[k].nmi) nmi_edge();
            cyc(5);
            pulse_ack();
            chk($sformatf("R2 valid %0d", k), grant_valid, 1);
            chk($sformatf("R2 src %0d", k), grant_src, TABLE[k].src);
            chk($sformatf("R5/R7 addr %0d", k), vec_addr, TABLE[k].addr);
            chk($sformatf("R5/R7 fetch %0d", k), vec_fetch, TABLE[k].fetch);
            chk($sformatf("R7 exec %0d", k), vec_exec_bus, TABLE[k].exec);
            pulse_done();
            int_n = 4'hF;
            cyc(4);
        end
        im_mode = 2'd1;

        // R2/R3/R4 trap and NMI arriving together
        pulse_set();
        trap_req = 1'b1; nmi_n = 1'b0; cyc(1); trap_req = 1'b0; cyc(1); nmi_n = 1'b1;
        cyc(5);
        pulse_ack();
        chk("R2 trap first", grant_src, 3'd0);
        chk("R3 trap addr", vec_addr, 32'h0);
        chk("R3 trap fetch", vec_fetch, 0);
        chk("R4 trap keeps gie", gie, 1);
        pulse_done();
        chk("R9 released", grant_valid, 0);
        pulse_ack();
        chk("R2 nmi second", grant_src, 3'd1);
        chk("R3 nmi addr", vec_addr, 32'h66);
        chk("R4 saved", nmi_saved_ie, 1);
        chk("R4 gie cleared", gie, 0);
        pulse_done();

        // R10 NMI held low: one service only
        nmi_n = 1'b0; cyc(5);
        pulse_ack();
        chk("R10 first", grant_src, 3'd1);
        chk("R4 saved zero", nmi_saved_ie, 0);
        pulse_done();
        cyc(3);
        chk("R10 no request", irq_req, 0);
        pulse_ack();
        chk("R10 no second", grant_valid, 0);
        nmi_n = 1'b1; cyc(3);

        // R9 hold while a higher source appears and ack repeats
        pulse_set();
        int_n = 4'b1011; cyc(4);
        pulse_ack();
        chk("R9 src", grant_src, 3'd4);
        int_n = 4'b1010; pulse_set(); cyc(3);
        pulse_ack();
        chk("R9 held valid", grant_valid, 1);
        chk("R9 held src", grant_src, 3'd4);
        chk("R9 held addr", vec_addr, 32'h1234_A604);
        pulse_done();
        chk("R9 done", grant_valid, 0);
        pulse_ack();
        chk("R9 next", grant_src, 3'd2);
        pulse_done();
        int_n = 4'hF; cyc(4);

        // R8 per-input enable and disable-all
        ier_we = 1'b1; ier_wdata = 4'b1101; cyc(1); ier_we = 1'b0;
        pulse_set();
        int_n = 4'b1001; cyc(4);
        pulse_ack();
        chk("R8 skip disabled", grant_src, 3'd4);
        pulse_done();
        pulse_set();
        chk("R8 req", irq_req, 1);
        gie_clr = 1'b1; cyc(1); gie_clr = 1'b0;
        chk("R8 gie off", gie, 0);
        chk("R8 ier kept", ier_q, 4'b1101);
        chk("R8 req off", irq_req, 0);
        pulse_ack();
        chk("R8 none", grant_valid, 0);
        int_n = 4'hF; cyc(4);

        // R11 acceptance clears gie over a same-cycle set
        pulse_set();
        int_n = 4'b1110; cyc(4);
        gie_set = 1'b1; ack = 1'b1; cyc(1); gie_set = 1'b0; ack = 1'b0;
        chk("R11 grant", grant_src, 3'd2);
        chk("R11 gie", gie, 0);
        pulse_done();
        int_n = 4'hF; cyc(4);

        // R2 NMI over INT0
        pulse_set();
        int_n = 4'b1110; nmi_edge(); cyc(5);
        pulse_ack();
        chk("R2 nmi over int0", grant_src, 3'd1);
        pulse_done();
        pulse_set();
        pulse_ack();
        chk("R2 int0 after", grant_src, 3'd2);
        pulse_done();
        int_n = 4'hF; cyc(3);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule